// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Trigger Modes

This block collects sixteen external interrupt request lines and presents one interrupt line to a processor. It is configured through a small 32-bit register bus with an address, a write enable, write data and read data. For each request line, software picks one of four trigger conditions: active-low level, active-high level, falling edge or rising edge. Software also gives each line a 3-bit priority. A global threshold lets through only the requests whose priority is above it. The winning request is reported in a status word that the interrupt handler reads to find the source.

Each request passes through a two-stage synchronizer before any level or edge logic sees it. An edge that is seen is held in a per-source latch until software clears it with a command write that names the source. A priority of zero turns a source off. Software masks and unmasks single sources by rewriting their priority field. The edge latch keeps collecting while a source is off, so an edge that arrives while the source is masked is not lost.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, every register reads 0. Reset leaves all sources in low-level mode with priority 0 and the controller disabled.
- R2: Bit 0 of the enable word (offset 0x00) gates forwarding. While it is 0, `cpuIrq` stays low and the status word reports no pending request (0x0001_0000).
- R3: A source in level mode is active while its synchronized input is 0 (code 00) or 1 (code 01).
- R4: In mode 11 a rising edge, and in mode 10 a falling edge, sets the source's latch. The latch stays set after the input returns. Latch bit n reads back at bit n of offset 0x80.
- R5: The priority of source n is held at offset 0x10 + 4*(n/2), bits [8*(n%2)+2 : 8*(n%2)]. Only those bits are stored, and every other bit of those words reads 0.
- R6: The 2-bit trigger code of source n is held at offset 0x04 + 4*(n/8), bits [2*(n%8)+1 : 2*(n%8)].
- R7: A source with priority 0 never wins. Its edge latch still sets while the priority is 0, and the source wins once a nonzero priority is restored.
- R8: A source is eligible only when it is active and its priority is strictly greater than the threshold in bits [2:0] of offset 0x40.
- R9: Among eligible sources the highest priority wins, and ties go to the lowest source number.
- R10: A write to offset 0x60 with bit 8 set clears the edge latch of the source given in bits [3:0]. The same write with bit 8 clear changes nothing.
- R11: The status word at offset 0xA0 is registered once per clock. Bit 16 is 0 when a request is pending, bits [10:8] hold the winner's priority and bits [4:0] hold its number, and all other bits are 0. `cpuIrq` is registered alongside it. An input change reaches both three clocks later in level mode and four clocks later in edge mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address (combinational) |
| irqIn | input | 16 | Asynchronous interrupt request lines |
| cpuIrq | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is an edge that arrives while its source is masked with priority zero. The test then has to show that the latch holds the edge, that the status word does not change, and that the source wins as soon as a priority is restored. The stimulus gives a falling-edge source priority 0 and pulses its line, then reads the pending register and the status word before and after rewriting the priority byte. The behavioural model tracks the synchronizer delay and the latches every clock, so the arbitration result is checked in every cycle in between, including the cycles around command writes that clear latches.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int SRC_CNT   = 16;
  localparam int PRIO_W    = 3;
  localparam int MODE_W    = 2;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int SRCS_MODE = DATA_W / (2 * MODE_W * 4) * 4;   // sources per mode word (8)
  localparam int MODE_WORDS = SRC_CNT / SRCS_MODE;
  localparam int LVL_WORDS  = SRC_CNT / 2;
  localparam int IDX_W      = $clog2(SRC_CNT);

  typedef enum logic [2:0] {
    RD_NONE, RD_CTL, RD_MODE, RD_LVL, RD_MASK, RD_PEND, RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic   wrCtl;
    logic   wrMode;
    logic   wrLevel;
    logic   wrMask;
    logic   wrClr;
    logic [2:0] wordIdx;
    rdSel_e rdSel;
  } ctlStb_t;

endpackage

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
  import irq_prio_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  output ctlStb_t       stb
);

  localparam logic [AW-1:0] OFS_CTL  = AW'(8'h00);
  localparam logic [AW-1:0] OFS_MODE = AW'(8'h04);
  localparam logic [AW-1:0] OFS_LVL  = AW'(8'h10);
  localparam logic [AW-1:0] OFS_MASK = AW'(8'h40);
  localparam logic [AW-1:0] OFS_CLR  = AW'(8'h60);
  localparam logic [AW-1:0] OFS_PEND = AW'(8'h80);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'hA0);

  logic [AW-1:0] modeOff, lvlOff;
  logic          aligned, isMode, isLvl;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign modeOff = busAddr - OFS_MODE;
  assign lvlOff  = busAddr - OFS_LVL;
  assign isMode  = aligned && (busAddr >= OFS_MODE) && (modeOff < AW'(4 * MODE_WORDS));
  assign isLvl   = aligned && (busAddr >= OFS_LVL) && (lvlOff < AW'(4 * LVL_WORDS));

  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_NONE;
    if (isMode) begin
      stb.rdSel   = RD_MODE;
      stb.wordIdx = 3'(modeOff >> 2);
      stb.wrMode  = busWe;
    end else if (isLvl) begin
      stb.rdSel   = RD_LVL;
      stb.wordIdx = 3'(lvlOff >> 2);
      stb.wrLevel = busWe;
    end else begin
      unique case (busAddr)
        OFS_CTL:  begin stb.rdSel = RD_CTL;  stb.wrCtl  = busWe; end
        OFS_MASK: begin stb.rdSel = RD_MASK; stb.wrMask = busWe; end
        OFS_CLR:  begin stb.wrClr = busWe; end
        OFS_PEND: stb.rdSel = RD_PEND;
        OFS_STAT: stb.rdSel = RD_STAT;
        default:  stb.rdSel = RD_NONE;
      endcase
    end
  end

  // at most one register is written per access
  p_one_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.wrCtl, stb.wrMode, stb.wrLevel, stb.wrMask, stb.wrClr}));

  // a write strobe only fires while the bus write enable is high
  p_write_needs_we_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrCtl || stb.wrMode || stb.wrLevel || stb.wrMask || stb.wrClr) |-> busWe);

endmodule

// File: rtl/irqp_datapath.sv
module irqp_datapath
  import irq_prio_pkg::*;
#(
  parameter int NSRC = SRC_CNT,
  parameter int PW   = PRIO_W,
  parameter int DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctlStb_t         stb,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] irqIn,
  output logic [DW-1:0]   rdata,
  output logic            cpuIrq
);

  localparam int IW      = $clog2(NSRC);
  localparam int PER_MW  = 8;

  logic [NSRC-1:0]      syncA, syncB, prevB, edgeLatch;
  logic [NSRC-1:0]      edgeSet, clrVec, active, elig;
  logic [2*NSRC-1:0]    modeVec;
  logic [PW*NSRC-1:0]   lvlVec;
  logic                 ctlEn;
  logic [PW-1:0]        maskLvl;
  logic [DW-1:0]        statReg;
  logic                 irqReg;
  logic [PW-1:0]        bestLvl;
  logic [IW-1:0]        bestIdx;
  logic                 hit;

  // per-source trigger evaluation
  for (genvar n = 0; n < NSRC; n++) begin : g_src
    logic [1:0]    mode;
    logic [PW-1:0] lvl;
    assign mode       = modeVec[2*n +: 2];
    assign lvl        = lvlVec[PW*n +: PW];
    assign edgeSet[n] = mode[1] && (mode[0] ? (syncB[n] && !prevB[n])
                                            : (!syncB[n] && prevB[n]));
    assign active[n]  = mode[1] ? edgeLatch[n] : (mode[0] ? syncB[n] : !syncB[n]);
    assign elig[n]    = active[n] && (lvl > maskLvl);
  end

  assign clrVec = (stb.wrClr && wdata[8]) ? (NSRC'(1) << wdata[IW-1:0]) : '0;

  // arbitration: descending scan with >= so lower index wins ties
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (lvlVec[PW*i +: PW] >= bestLvl)) begin
        bestLvl = lvlVec[PW*i +: PW];
        bestIdx = IW'(i);
      end
    end
  end

  assign hit = ctlEn && (elig != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA     <= '0;
      syncB     <= '0;
      prevB     <= '0;
      edgeLatch <= '0;
      modeVec   <= '0;
      lvlVec    <= '0;
      ctlEn     <= 1'b0;
      maskLvl   <= '0;
      statReg   <= '0;
      irqReg    <= 1'b0;
    end else begin
      syncA     <= irqIn;
      syncB     <= syncA;
      prevB     <= syncB;
      edgeLatch <= (edgeLatch & ~clrVec) | edgeSet;
      if (stb.wrCtl)  ctlEn   <= wdata[0];
      if (stb.wrMask) maskLvl <= wdata[PW-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (stb.wrMode && (32'(i / PER_MW) == 32'(stb.wordIdx)))
          modeVec[2*i +: 2] <= wdata[2*(i % PER_MW) +: 2];
        if (stb.wrLevel && (32'(i / 2) == 32'(stb.wordIdx)))
          lvlVec[PW*i +: PW] <= wdata[8*(i % 2) +: PW];
      end
      irqReg  <= hit;
      statReg <= '0;
      statReg[16]     <= !hit;
      if (hit) begin
        statReg[8 +: PW] <= bestLvl;
        statReg[0 +: IW] <= bestIdx;
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (stb.rdSel)
      RD_CTL:  rdata[0] = ctlEn;
      RD_MASK: rdata[PW-1:0] = maskLvl;
      RD_PEND: rdata[NSRC-1:0] = edgeLatch;
      RD_STAT: rdata = statReg;
      RD_MODE:
        for (int i = 0; i < NSRC; i++)
          if (32'(i / PER_MW) == 32'(stb.wordIdx))
            rdata[2*(i % PER_MW) +: 2] = modeVec[2*i +: 2];
      RD_LVL:
        for (int i = 0; i < NSRC; i++)
          if (32'(i / 2) == 32'(stb.wordIdx))
            rdata[8*(i % 2) +: PW] = lvlVec[PW*i +: PW];
      default: rdata = '0;
    endcase
  end

  assign cpuIrq = irqReg;

  // forwarding stops one clock after the enable drops
  p_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctlEn |=> (!cpuIrq && statReg[16]));

  // detected edges are captured in the latch
  p_edge_captured_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (edgeSet != '0) |=> ((edgeLatch & $past(edgeSet)) == $past(edgeSet)));

  // a clear command with no competing edge empties the latch
  p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((clrVec & ~edgeSet) != '0) |=> ((edgeLatch & $past(clrVec & ~edgeSet)) == '0));

  // a forwarded winner sits above the threshold that selected it
  p_above_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuIrq && $stable(maskLvl)) |-> (statReg[8 +: PW] > maskLvl));

  // pending flag and the interrupt output agree after the first update
  p_flag_agrees_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> (cpuIrq == !statReg[16]));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC = SRC_CNT,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   busAddr,
  input  logic            busWe,
  input  logic [DW-1:0]   busWdata,
  output logic [DW-1:0]   busRdata,
  input  logic [NSRC-1:0] irqIn,
  output logic            cpuIrq
);

  ctlStb_t stb;

  irqp_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  irqp_datapath #(.NSRC(NSRC), .PW(PRIO_W), .DW(DW)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .wdata  (busWdata),
    .irqIn  (irqIn),
    .rdata  (busRdata),
    .cpuIrq (cpuIrq)
  );

endmodule

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = 8'hA0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [15:0] irqIn = '0;
  logic [31:0] busRdata;
  logic        cpuIrq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .cpuIrq(cpuIrq)
  );

  // ---------------- behavioural reference model ----------------
  bit [15:0] ms1, ms2, mprev, mlatch;
  int        mmode [16];
  int        mlvl  [16];
  bit        men;
  int        mmask;
  bit [31:0] mcsr;
  bit        mirq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; mprev = 0; mlatch = 0;
      for (int i = 0; i < 16; i++) begin mmode[i] = 0; mlvl[i] = 0; end
      men = 0; mmask = 0; mcsr = 0; mirq = 0;
    end else begin
      int best;
      int bl;
      bit [15:0] nl;
      best = -1; bl = 0;
      for (int i = 0; i < 16; i++) begin
        bit act;
        if (mmode[i] >= 2) act = mlatch[i];
        else if (mmode[i] == 1) act = ms2[i];
        else act = !ms2[i];
        if (men && act && mlvl[i] > mmask && mlvl[i] > bl) begin
          bl = mlvl[i]; best = i;
        end
      end
      mirq = (best >= 0);
      mcsr = mirq ? ((bl << 8) | best) : 32'h0001_0000;
      nl = mlatch;
      if (busWe && busAddr == 8'h60 && busWdata[8]) nl[busWdata[3:0]] = 1'b0;
      for (int i = 0; i < 16; i++) begin
        if (mmode[i] == 3 && ms2[i] && !mprev[i]) nl[i] = 1'b1;
        if (mmode[i] == 2 && !ms2[i] && mprev[i]) nl[i] = 1'b1;
      end
      mlatch = nl;
      if (busWe) begin
        if (busAddr == 8'h00) men = busWdata[0];
        if (busAddr == 8'h40) mmask = busWdata[2:0];
        if (busAddr == 8'h04 || busAddr == 8'h08)
          for (int j = 0; j < 8; j++)
            mmode[(busAddr == 8'h08 ? 8 : 0) + j] = busWdata[2*j +: 2];
        if (busAddr >= 8'h10 && busAddr <= 8'h2C && busAddr[1:0] == 0) begin
          mlvl[2*((busAddr - 8'h10) / 4)]     = busWdata[2:0];
          mlvl[2*((busAddr - 8'h10) / 4) + 1] = busWdata[10:8];
        end
      end
      mprev = ms2; ms2 = ms1; ms1 = irqIn;
    end
  end

  function automatic bit [31:0] mread(input bit [7:0] a);
    bit [31:0] r = 0;
    if (a == 8'h00) r = men;
    else if (a == 8'h04 || a == 8'h08)
      for (int j = 0; j < 8; j++) r[2*j +: 2] = mmode[(a == 8'h08 ? 8 : 0) + j];
    else if (a >= 8'h10 && a <= 8'h2C && a[1:0] == 0) begin
      r[2:0]  = mlvl[2*((a - 8'h10) / 4)];
      r[10:8] = mlvl[2*((a - 8'h10) / 4) + 1];
    end
    else if (a == 8'h40) r = mmask;
    else if (a == 8'h80) r = mlatch;
    else if (a == 8'hA0) r = mcsr;
    return r;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model (R11)
  always begin
    @(posedge clk);
    #1;
    if (rst_n && !done) begin
      chk("R11 cpuIrq", {31'b0, cpuIrq}, {31'b0, mirq});
      if (!busWe && busAddr == 8'hA0) chk("R11 status word", busRdata, mcsr);
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = 8'hA0; busWdata = '0;
  endtask

  task automatic rdK(input bit [7:0] a, input bit [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    chk(tag, busRdata, exp);
    chk({tag, " model"}, busRdata, mread(a));
    busAddr = 8'hA0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R11 watchdog expired: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    waitc(2);
    rdK(8'h00, 32'h0, "R1 enable at reset");
    rdK(8'h04, 32'h0, "R1 mode at reset");
    rdK(8'h14, 32'h0, "R1 level at reset");
    rdK(8'h40, 32'h0, "R1 mask at reset");
    rdK(8'h80, 32'h0, "R1 pending at reset");
    rdK(8'hA0, 32'h0, "R1 status at reset");
    chk("R1 cpuIrq at reset", {31'b0, cpuIrq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R6: mode packing (src3 high, src10 high, src12 rising, src13 falling)
    wr(8'h04, 32'h0000_0040);
    wr(8'h08, 32'h0000_0B10);
    rdK(8'h04, 32'h0000_0040, "R6 mode word 0");
    rdK(8'h08, 32'h0000_0B10, "R6 mode word 1");

    // R5: level packing, only 3 bits per byte stored
    wr(8'h14, 32'hFFFF_FFFF);
    rdK(8'h14, 32'h0000_0707, "R5 level bits");
    wr(8'h14, 32'h0000_0500);
    rdK(8'h14, 32'h0000_0500, "R5 src3 level");

    // R2: disabled controller forwards nothing
    irqIn[3] = 1'b1; irqIn[13] = 1'b1;
    waitc(6);
    rdK(8'hA0, 32'h0001_0000, "R2 disabled status");
    chk("R2 disabled cpuIrq", {31'b0, cpuIrq}, 32'h0);

    // R3: high level source after enable
    wr(8'h00, 32'h1);
    waitc(4);
    rdK(8'hA0, 32'h0000_0503, "R3 high level");
    chk("R3 cpuIrq", {31'b0, cpuIrq}, 32'h1);

    // R8: strict threshold
    wr(8'h40, 32'h5);
    waitc(3);
    rdK(8'hA0, 32'h0001_0000, "R8 level equal to mask");
    wr(8'h40, 32'h4);
    waitc(3);
    rdK(8'hA0, 32'h0000_0503, "R8 level above mask");

    // R9: tie to lower index, then higher priority wins
    wr(8'h24, 32'h5);
    irqIn[10] = 1'b1;
    waitc(5);
    rdK(8'hA0, 32'h0000_0503, "R9 tie lowest index");
    wr(8'h24, 32'h7);
    waitc(3);
    rdK(8'hA0, 32'h0000_070A, "R9 higher priority");

    // R3: low level source
    wr(8'h10, 32'h6);
    irqIn[10] = 1'b0;
    waitc(5);
    rdK(8'hA0, 32'h0000_0600, "R3 low level active");
    irqIn[0] = 1'b1;
    waitc(5);
    rdK(8'hA0, 32'h0000_0503, "R3 low level released");

    // R4: rising edge latched and held
    wr(8'h28, 32'h6);
    irqIn[12] = 1'b1; waitc(2); irqIn[12] = 1'b0;
    waitc(6);
    rdK(8'hA0, 32'h0000_060C, "R4 edge held");
    rdK(8'h80, 32'h0000_1000, "R4 pending bit");

    // R10: clear command needs bit 8
    wr(8'h60, 32'h0000_000C);
    waitc(3);
    rdK(8'h80, 32'h0000_1000, "R10 no clear without bit 8");
    wr(8'h60, 32'h0000_010C);
    waitc(3);
    rdK(8'h80, 32'h0000_0000, "R10 latch cleared");
    rdK(8'hA0, 32'h0000_0503, "R10 status after clear");

    // R7: edge latched while priority is 0, wins after unmask
    irqIn[13] = 1'b0;
    waitc(6);
    rdK(8'h80, 32'h0000_2000, "R7 latched at level 0");
    rdK(8'hA0, 32'h0000_0503, "R7 level 0 does not win");
    wr(8'h28, 32'h0000_0706);
    waitc(3);
    rdK(8'hA0, 32'h0000_070D, "R7 unmasked source wins");
    wr(8'h60, 32'h0000_010D);
    waitc(3);
    rdK(8'hA0, 32'h0000_0503, "R7 after clear");

    // R2: disable again
    wr(8'h00, 32'h0);
    waitc(3);
    rdK(8'hA0, 32'h0001_0000, "R2 disabled again");
    chk("R2 cpuIrq low", {31'b0, cpuIrq}, 32'h0);

    waitc(2);
    summary();
    $finish;
  end

endmodule